// File: doc/BRIEF.md
# Reference Clock Activity Monitor

This block watches a set of reference clock inputs and reports, for the currently selected one, whether that reference has gone quiet. Activity is judged against a phase-detector feedback clock. Each rising or falling transition of the feedback clock opens a new observation step. If a step closes with no transition of the reference, it counts as a miss. After a set number of misses in a row, the loss flag rises. Any reference transition, of either polarity and in any number, clears the miss count.

Each reference port has its own monitor. A port index picks which monitor drives the single loss output. That output goes to system status and to an automatic switchover controller. The block runs from one fast sampling clock. The feedback clock and every reference clock enter through synchronizer chains, and transitions are found by comparing successive synchronized samples.

Top module: `ref_activity_monitor`

## Requirements
- R1: After reset is asserted (rstN low), every miss count and every loss flag is zero, so lossOut reads 0.
- R2: Every rising and every falling transition of fbClk is one observation step. A step in which the monitored reference shows no transition is a miss. The flag of a port reads 1 after MISS_LIMIT (default 3) consecutive misses.
- R3: A single reference transition of either polarity within a step counts as activity for that step.
- R4: Many reference transitions within one step are treated the same as one, and never raise the flag.
- R5: While misses continue, the count saturates at MISS_LIMIT and the flag stays 1. It does not wrap and does not drop.
- R6: The flag returns to 0 at the first feedback transition whose step contained reference activity, and the miss count restarts from zero.
- R7: lossOut shows the flag of port 0 when refSel is 0 and the flag of port 1 when refSel is 1. A value of 1 means loss and 0 means an active reference.
- R8: The monitors are independent. Activity or loss on one port does not change the flag of another port.
- R9: While fbClk makes no transition, no flag changes, whatever the references do.
- R10: An input transition takes two synchronizer stages plus one edge-detect stage to reach the flags. A feedback transition sampled at clock edge n updates the flags at clock edge n+2.

Both refClk bits and fbClk are sampled on clk. Bit i of refClk is reference port i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, faster than every monitored clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fbClk | input | 1 | Phase-detector feedback clock; both of its transitions are counted |
| refClk | input | 2 | Reference clocks, one bit per port |
| refSel | input | 1 | Index of the port whose flag drives lossOut |
| lossOut | output | 1 | Loss of reference for the selected port; 1 means loss |

## Verification
The case hardest to reach from the ports is a reference that switches exactly once in an observation step and then stops. Recovery must then happen on that single edge, and the miss count must restart from it. To reach it, the stimulus holds a reference until the flag has risen and saturated. It then flips that reference once, first rising and later falling, and holds it again. The feedback clock keeps running throughout. A behavioural model is compared on every cycle, so the exact edge at which the flag falls and rises again is checked. Separate phases freeze the feedback clock while the references move, and run a reference at the sampling rate to pack many transitions into one step.

// File: rtl/ref_monitor_pkg.sv
package ref_monitor_pkg;
  parameter int REF_PORTS = 2;

  typedef struct packed {
    logic                 fbEdge;
    logic [REF_PORTS-1:0] refEdge;
  } actStrobe_t;
endpackage

// File: rtl/edge_capture.sv
module edge_capture
  import ref_monitor_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fbClk,
  input  logic [REF_PORTS-1:0] refClk,
  output actStrobe_t           strobes
);
  localparam int CHAINS = REF_PORTS + 1;

  logic [CHAINS-1:0] rawIn;
  logic [CHAINS-1:0] synced;
  logic [CHAINS-1:0] lastSeen;

  assign rawIn = {fbClk, refClk};

  for (genvar c = 0; c < CHAINS; c++) begin : g_chain
    logic [SYNC_STAGES-1:0] stageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ      <= '0;
        lastSeen[c] <= 1'b0;
      end else begin
        stageQ      <= {stageQ[SYNC_STAGES-2:0], rawIn[c]};
        lastSeen[c] <= stageQ[SYNC_STAGES-1];
      end
    end
    assign synced[c] = stageQ[SYNC_STAGES-1];
  end

  always_comb begin
    strobes.fbEdge  = synced[CHAINS-1] ^ lastSeen[CHAINS-1];
    strobes.refEdge = synced[REF_PORTS-1:0] ^ lastSeen[REF_PORTS-1:0];
  end
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import ref_monitor_pkg::*;
#(
  parameter int MISS_LIMIT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  actStrobe_t           strobes,
  output logic [REF_PORTS-1:0] lossFlags
);
  localparam int CNT_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(MISS_LIMIT);

  for (genvar p = 0; p < REF_PORTS; p++) begin : g_port
    logic [CNT_W-1:0] missCnt;
    logic             seenAct;
    logic             stepAct;
    logic [CNT_W-1:0] bumpCnt;

    assign stepAct = seenAct | strobes.refEdge[p];
    assign bumpCnt = (missCnt == LIMIT_V) ? missCnt : missCnt + 1'b1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        missCnt      <= '0;
        seenAct      <= 1'b0;
        lossFlags[p] <= 1'b0;
      end else if (strobes.fbEdge) begin
        seenAct <= 1'b0;
        if (stepAct) begin
          missCnt      <= '0;
          lossFlags[p] <= 1'b0;
        end else begin
          missCnt      <= bumpCnt;
          lossFlags[p] <= (bumpCnt >= LIMIT_V);
        end
      end else if (strobes.refEdge[p]) begin
        seenAct <= 1'b1;
      end
    end

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
      missCnt <= LIMIT_V);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.fbEdge |=> $stable(lossFlags[p]));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(lossFlags[p]) |-> $past(stepAct) && $past(strobes.fbEdge));

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(lossFlags[p]) |-> missCnt == LIMIT_V);
  end
endmodule

// File: rtl/ref_activity_monitor.sv
module ref_activity_monitor
  import ref_monitor_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MISS_LIMIT  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fbClk,
  input  logic [REF_PORTS-1:0] refClk,
  input  logic                 refSel,
  output logic                 lossOut
);
  actStrobe_t           strobes;
  logic [REF_PORTS-1:0] lossFlags;

  edge_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk    (clk),
    .rstN   (rstN),
    .fbClk  (fbClk),
    .refClk (refClk),
    .strobes(strobes)
  );

  miss_tracker #(.MISS_LIMIT(MISS_LIMIT)) u_tracker (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .lossFlags(lossFlags)
  );

  assign lossOut = lossFlags[refSel];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> lossFlags == '0);
endmodule

// File: tb/ref_activity_monitor_bench.sv
module ref_activity_monitor_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fbClk = 1'b0;
  logic [1:0] refClk = 2'b00;
  logic       refSel = 1'b0;
  logic       lossOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  ref_activity_monitor u_ref_activity_monitor (
    .clk(clk), .rstN(rstN), .fbClk(fbClk),
    .refClk(refClk), .refSel(refSel), .lossOut(lossOut)
  );

  // behavioural model
  logic [2:0] hist[$];
  int  mCnt[2];
  bit  mSeen[2];
  bit  mFlag[2];

  task automatic check(input string req, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: lossOut=%0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      hist = '{3'b000, 3'b000, 3'b000};
      for (int p = 0; p < 2; p++) begin mCnt[p] = 0; mSeen[p] = 0; mFlag[p] = 0; end
    end else begin
      logic [2:0] cur, prv;
      bit fbE;
      hist.push_back({fbClk, refClk});
      cur = hist[hist.size()-3];
      prv = hist[hist.size()-4];
      fbE = cur[2] != prv[2];
      for (int p = 0; p < 2; p++) begin
        bit rE;
        rE = cur[p] != prv[p];
        if (fbE) begin
          if (mSeen[p] || rE) begin mCnt[p] = 0; mFlag[p] = 0; end
          else begin
            if (mCnt[p] < 3) mCnt[p]++;
            mFlag[p] = (mCnt[p] >= 3);
          end
          mSeen[p] = 0;
        end else if (rE) mSeen[p] = 1;
      end
      if (hist.size() > 8) void'(hist.pop_front());
    end
    #1;
    check(tag, lossOut, mFlag[refSel]);
  end

  // watchdog
  initial begin
    #(150000 * 5);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int fbCtr = 0, r0Ctr = 0, r1Ctr = 0;

  // half periods in sampling cycles; 0 holds the signal
  task automatic run(input int n, input int fbH, input int r0H, input int r1H);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fbH > 0) begin fbCtr++; if (fbCtr >= fbH) begin fbCtr = 0; fbClk = ~fbClk; end end
      if (r0H > 0) begin r0Ctr++; if (r0Ctr >= r0H) begin r0Ctr = 0; refClk[0] = ~refClk[0]; end end
      if (r1H > 0) begin r1Ctr++; if (r1Ctr >= r1H) begin r1Ctr = 0; refClk[1] = ~refClk[1]; end end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    @(negedge clk); #0.1;
    check("R1", lossOut, 1'b0);
    rstN = 1'b1;
    tag = "R2";
    run(60, 4, 3, 2);
    check("R2", lossOut, 1'b0);
    // stop ref0 low: loss after three feedback transitions
    run(40, 4, 0, 2);
    check("R2", lossOut, 1'b1);
    tag = "R5";
    run(120, 4, 0, 2);
    check("R5", lossOut, 1'b1);
    // single rising edge on ref0
    tag = "R3";
    @(negedge clk); refClk[0] = 1'b1;
    run(10, 4, 0, 2);
    check("R3", lossOut, 1'b0);
    run(40, 4, 0, 2);
    check("R6", lossOut, 1'b1);
    // single falling edge on ref0
    @(negedge clk); refClk[0] = 1'b0;
    run(10, 4, 0, 2);
    check("R3", lossOut, 1'b0);
    run(40, 4, 0, 2);
    // burst of transitions, many per step
    tag = "R4";
    run(80, 8, 1, 2);
    check("R4", lossOut, 1'b0);
    // port 1 lost while port 0 active
    tag = "R7";
    run(60, 4, 3, 0);
    check("R8", lossOut, 1'b0);
    @(negedge clk); refSel = 1'b1;
    #0.1 check("R7", lossOut, 1'b1);
    run(20, 4, 3, 0);
    check("R7", lossOut, 1'b1);
    tag = "R6";
    run(40, 4, 3, 5);
    check("R6", lossOut, 1'b0);
    // feedback frozen: no flag moves
    tag = "R9";
    @(negedge clk); refSel = 1'b0;
    run(200, 0, 0, 0);
    check("R9", lossOut, 1'b0);
    run(30, 0, 1, 3);
    check("R9", lossOut, 1'b0);
    // slow feedback, long hold then recovery
    tag = "R10";
    run(300, 13, 0, 7);
    check("R10", lossOut, 1'b1);
    run(100, 13, 9, 7);
    check("R10", lossOut, 1'b0);
    // reset mid-loss
    tag = "R1";
    run(60, 4, 0, 0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); #0.1;
    check("R1", lossOut, 1'b0);
    fbClk = 1'b0; refClk = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    run(20, 4, 3, 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule